// File: doc/BRIEF.md
# Periodic Waveform Spike Encoder

This block turns two periodic test waveforms into place-coded spike trains for a spiking network. Each waveform is a sinusoid whose period, counted in time slices, is set at an input port. The sine value is quantised onto nine amplitude levels, and each level owns one spike line. On firing slices the single line that matches the level of the active waveform pulses for one clock.

The block also runs the presentation schedule on its own. It shows one waveform for a fixed number of slices and then switches to the other. During an initial training window it inserts a silent interval after each segment, and no spike is sent in that interval. Once the training window is over, the segments follow each other with no gap. A flag output shows which waveform is active. Both phase generators advance on every slice, whether their waveform is active or not, so a waveform comes back at the phase it would have reached by running without a break.

Top module: `spike_place_encoder`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every spike line is low and `wave_b_o` is 0 (waveform A).
- R2: At most one spike line is high in any cycle. A spike lasts exactly one clock and appears only in the cycle that follows a clock edge at which `slice_i` was high.
- R3: Slices are numbered from 0 after reset. Only slices whose number is a multiple of FIRE_DIV can fire. Every other slice leaves all lines low.
- R4: A firing slice t drives bit L of `spike_o`, where L = 4 + round(4·sin(2π·i/32)), i = floor(32·p/P), p = t mod P, and P is the period of the active waveform. Both periods must lie between 32 and 2^PERIOD_W − 1.
- R5: Both waveforms' phases advance on every slice, including slices where the waveform is inactive and slices in a silent interval.
- R6: During training, each segment of SEG_LEN slices is followed by GAP_LEN silent slices in which every line stays low.
- R7: A silent interval follows a segment only if the total slice count at the end of that segment is below TRAIN_LEN. After that point, segments follow each other directly and firing continues on the R3 cadence.
- R8: The first segment uses waveform A. `wave_b_o` toggles only at the clock edge of a segment's last slice, and it holds in every cycle without a slice strobe. During a silent interval it already shows the next waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slice_i | input | 1 | Time-slice strobe, one clock per slice |
| period_a_i | input | PERIOD_W | Period of waveform A in slices |
| period_b_i | input | PERIOD_W | Period of waveform B in slices |
| spike_o | output | 9 | One-hot spike lines, bit k = level k |
| wave_b_o | output | 1 | 1 while waveform B is active |

## Verification
The bench builds two copies of the block, one with the folded quarter-wave table and one with the flat table. Both use SEG_LEN=60, GAP_LEN=12, TRAIN_LEN=300 and FIRE_DIV=3. With these values, four gapped segments, the segment that crosses the end of training and several gap-free segments all fall within 700 slices. Every slice is compared against a level computed in the bench from the sine function. Each run uses one pair of periods: 43 and 133, then the extremes 32 and 255. The strobe is applied every second cycle in one run and in irregular bursts of back-to-back strobes in the other.

// File: rtl/spk_enc_pkg.sv
package spk_enc_pkg;

   localparam int NUM_LEVELS = 9;
   localparam int MID_LEVEL  = (NUM_LEVELS - 1) / 2;
   localparam int TAB_N      = 32;
   localparam int TAB_W      = $clog2(TAB_N);
   localparam int QTR_N      = TAB_N / 4;
   localparam int LVL_W      = $clog2(NUM_LEVELS);

   typedef logic [LVL_W-1:0] level_t;
   typedef logic [TAB_W-1:0] tab_idx_t;
   typedef level_t level_rom_t [TAB_N];

   // rounded 4*sin(k*pi/16) for k = 0..8
   function automatic int quarter_amp(input int k);
      int a;
      case (k)
         0:       a = 0;
         1:       a = 1;
         2, 3:    a = 2;
         4, 5:    a = 3;
         default: a = 4;
      endcase
      return a;
   endfunction

   function automatic level_t fold_level(input int idx);
      int quad;
      int off;
      int k;
      int amp;
      quad = idx / QTR_N;
      off  = idx % QTR_N;
      k    = (quad % 2 == 1) ? (QTR_N - off) : off;
      amp  = quarter_amp(k);
      return level_t'((quad >= 2) ? (MID_LEVEL - amp) : (MID_LEVEL + amp));
   endfunction

   function automatic level_rom_t build_rom();
      level_rom_t r;
      for (int i = 0; i < TAB_N; i++) r[i] = fold_level(i);
      return r;
   endfunction

endpackage

// File: rtl/spk_sine_level.sv
module spk_sine_level
   import spk_enc_pkg::*;
#(
   parameter bit QUARTER_ROM = 1'b1
) (
   input  tab_idx_t idx_i,
   output level_t   level_o
);

   generate
      if (QUARTER_ROM) begin : g_quarter
         logic [1:0]       quad;
         logic [TAB_W-3:0] off;
         logic [TAB_W-2:0] k;
         level_t           amp;

         assign quad = idx_i[TAB_W-1 -: 2];
         assign off  = idx_i[TAB_W-3:0];
         assign k    = quad[0] ? ((TAB_W-1)'(QTR_N) - {1'b0, off}) : {1'b0, off};

         always_comb amp = level_t'(quarter_amp(int'(k)));

         assign level_o = quad[1] ? (level_t'(MID_LEVEL) - amp)
                                  : (level_t'(MID_LEVEL) + amp);
      end else begin : g_full
         localparam level_rom_t ROM = build_rom();
         assign level_o = ROM[idx_i];
      end
   endgenerate

endmodule

// File: rtl/spk_wave_phase.sv
module spk_wave_phase
   import spk_enc_pkg::*;
#(
   parameter int PERIOD_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                step_i,
   input  logic [PERIOD_W-1:0] period_i,
   output tab_idx_t            idx_o
);

   localparam int ERR_W = PERIOD_W + 1;

   logic [PERIOD_W-1:0] pos_q;
   tab_idx_t            idx_q;
   logic [ERR_W-1:0]    err_q;
   logic [ERR_W-1:0]    err_sum;
   logic [ERR_W-1:0]    per_ext;
   logic                wrap;

   assign per_ext = ERR_W'(period_i);
   assign wrap    = (ERR_W'(pos_q) + ERR_W'(1)) >= per_ext;
   assign err_sum = err_q + ERR_W'(TAB_N);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q <= '0;
         idx_q <= '0;
         err_q <= '0;
      end else if (step_i) begin
         if (wrap) begin
            pos_q <= '0;
            idx_q <= '0;
            err_q <= '0;
         end else begin
            pos_q <= pos_q + PERIOD_W'(1);
            if (err_sum >= per_ext) begin
               idx_q <= idx_q + TAB_W'(1);
               err_q <= err_sum - per_ext;
            end else begin
               err_q <= err_sum;
            end
         end
      end
   end

   assign idx_o = idx_q;

   // R4
   period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |-> (period_i >= PERIOD_W'(TAB_N)));

   // R5
   phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> $stable(idx_q));

endmodule

// File: rtl/spk_stim_sched.sv
module spk_stim_sched #(
   parameter int SEG_LEN   = 500,
   parameter int GAP_LEN   = 100,
   parameter int TRAIN_LEN = 6000,
   parameter int FIRE_DIV  = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic slice_i,
   output logic fire_o,
   output logic sel_b_o
);

   localparam int CNT_MAX = (SEG_LEN > GAP_LEN) ? SEG_LEN : GAP_LEN;
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam int TOT_W   = $clog2(TRAIN_LEN + 1);
   localparam int DIV_W   = $clog2(FIRE_DIV);

   localparam logic [CNT_W-1:0] SEG_LAST = CNT_W'(SEG_LEN - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_LEN - 1);
   localparam logic [TOT_W-1:0] TOT_END  = TOT_W'(TRAIN_LEN);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FIRE_DIV - 1);

   logic             gap_q;
   logic             sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [TOT_W-1:0] tot_q;
   logic [DIV_W-1:0] div_q;
   logic             seg_end;
   logic             gap_end;
   logic             still_training;

   assign seg_end        = !gap_q && (cnt_q == SEG_LAST);
   assign gap_end        =  gap_q && (cnt_q == GAP_LAST);
   assign still_training = (int'(tot_q) + 1) < TRAIN_LEN;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q <= 1'b0;
         sel_q <= 1'b0;
         cnt_q <= '0;
         tot_q <= '0;
         div_q <= '0;
      end else if (slice_i) begin
         div_q <= (div_q == DIV_LAST) ? '0 : (div_q + DIV_W'(1));
         if (tot_q != TOT_END) tot_q <= tot_q + TOT_W'(1);
         if (seg_end) begin
            sel_q <= ~sel_q;
            cnt_q <= '0;
            gap_q <= still_training;
         end else if (gap_end) begin
            gap_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign fire_o  = slice_i && (div_q == '0) && !gap_q;
   assign sel_b_o = sel_q;

   // R3
   div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_q <= DIV_LAST);

   // R6
   gap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gap_q |-> (cnt_q <= GAP_LAST));

   // R6
   gap_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gap_q) |-> !$stable(sel_q));

   // R7
   post_train_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((tot_q == TOT_END) && !gap_q) |=> !gap_q);

   // R8
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slice_i |=> $stable(sel_q));

endmodule

// File: rtl/spike_place_encoder.sv
module spike_place_encoder
   import spk_enc_pkg::*;
#(
   parameter int PERIOD_W    = 8,
   parameter int SEG_LEN     = 500,
   parameter int GAP_LEN     = 100,
   parameter int TRAIN_LEN   = 6000,
   parameter int FIRE_DIV    = 3,
   parameter bit QUARTER_ROM = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  slice_i,
   input  logic [PERIOD_W-1:0]   period_a_i,
   input  logic [PERIOD_W-1:0]   period_b_i,
   output logic [NUM_LEVELS-1:0] spike_o,
   output logic                  wave_b_o
);

   localparam int NUM_WAVES = 2;

   generate
      if (PERIOD_W < TAB_W + 1) begin : g_bad_period_w
         $error("PERIOD_W too narrow for the minimum period");
      end
      if (FIRE_DIV < 2) begin : g_bad_div
         $error("FIRE_DIV must be at least 2");
      end
      if (SEG_LEN < 2 || GAP_LEN < 1 || TRAIN_LEN < 1) begin : g_bad_sched
         $error("schedule lengths out of range");
      end
   endgenerate

   logic                fire;
   logic                sel_b;
   logic [PERIOD_W-1:0] period_w [NUM_WAVES];
   tab_idx_t            idx_w    [NUM_WAVES];
   tab_idx_t            act_idx;
   level_t              level;
   logic [NUM_LEVELS-1:0] spike_q;

   assign period_w[0] = period_a_i;
   assign period_w[1] = period_b_i;

   spk_stim_sched #(
      .SEG_LEN   (SEG_LEN),
      .GAP_LEN   (GAP_LEN),
      .TRAIN_LEN (TRAIN_LEN),
      .FIRE_DIV  (FIRE_DIV)
   ) u_sched (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .slice_i (slice_i),
      .fire_o  (fire),
      .sel_b_o (sel_b)
   );

   generate
      for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
         spk_wave_phase #(
            .PERIOD_W (PERIOD_W)
         ) u_phase (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .step_i   (slice_i),
            .period_i (period_w[w]),
            .idx_o    (idx_w[w])
         );
      end
   endgenerate

   assign act_idx = idx_w[sel_b];

   spk_sine_level #(
      .QUARTER_ROM (QUARTER_ROM)
   ) u_level (
      .idx_i   (act_idx),
      .level_o (level)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         spike_q <= '0;
      end else begin
         spike_q <= '0;
         if (fire) spike_q <= NUM_LEVELS'(1) << level;
      end
   end

   assign spike_o  = spike_q;
   assign wave_b_o = sel_b;

   // R2
   spike_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(spike_q));

   // R2
   spike_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spike_q != '0) |-> $past(slice_i));

endmodule

// File: tb/spike_place_encoder_bench.sv
`timescale 1ns/1ps
module spike_place_encoder_bench;

   localparam int B_PW    = 8;
   localparam int B_SEG   = 60;
   localparam int B_GAP   = 12;
   localparam int B_TRAIN = 300;
   localparam int B_DIV   = 3;
   localparam int N_SLICE = 700;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slice_i = 1'b0;
   logic [7:0] period_a = 8'd43;
   logic [7:0] period_b = 8'd133;
   logic [8:0] spike_q4, spike_fl;
   logic       wave_q4, wave_fl;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   int t, m_sel, m_gap, m_cnt;
   logic [8:0] exp_spike;
   logic       exp_sel;
   string      exp_tag;

   always #4 clk = ~clk;

   spike_place_encoder #(
      .PERIOD_W(B_PW), .SEG_LEN(B_SEG), .GAP_LEN(B_GAP),
      .TRAIN_LEN(B_TRAIN), .FIRE_DIV(B_DIV), .QUARTER_ROM(1'b1)
   ) u_spike_place_encoder (
      .clk_i(clk), .rst_ni(rst_n), .slice_i(slice_i),
      .period_a_i(period_a), .period_b_i(period_b),
      .spike_o(spike_q4), .wave_b_o(wave_q4)
   );

   spike_place_encoder #(
      .PERIOD_W(B_PW), .SEG_LEN(B_SEG), .GAP_LEN(B_GAP),
      .TRAIN_LEN(B_TRAIN), .FIRE_DIV(B_DIV), .QUARTER_ROM(1'b0)
   ) u_spike_place_encoder_full (
      .clk_i(clk), .rst_ni(rst_n), .slice_i(slice_i),
      .period_a_i(period_a), .period_b_i(period_b),
      .spike_o(spike_fl), .wave_b_o(wave_fl)
   );

   function automatic int exp_level(input int p, input int per);
      int  idx;
      real a;
      real r;
      idx = (p * 32) / per;
      a   = 4.0 * $sin(2.0 * 3.14159265358979 * idx / 32.0);
      r   = (a >= 0.0) ? $floor(a + 0.5) : -$floor(-a + 0.5);
      return 4 + $rtoi(r);
   endfunction

   task automatic check_bits(input logic [8:0] act, input logic [8:0] exp,
                             input string tag, input string what);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s slice=%0d actual=%b expected=%b", tag, what, t, act, exp);
      end
   endtask

   task automatic check_outputs();
      check_bits(spike_q4, exp_spike, exp_tag, "spike/quarter");
      check_bits(spike_fl, exp_spike, exp_tag, "spike/full");
      check_bits({8'd0, wave_q4}, {8'd0, exp_sel}, "R8", "flag");
      check_bits({8'd0, ($countones(spike_q4) <= 1)}, 9'd1, "R2", "one-hot");
   endtask

   task automatic do_cycle(input logic s);
      int per;
      int lvl;
      bit fire;
      @(negedge clk);
      check_outputs();
      slice_i = s;
      if (s) begin
         per  = (m_sel != 0) ? int'(period_b) : int'(period_a);
         lvl  = exp_level(t % per, per);
         fire = ((t % B_DIV) == 0) && (m_gap == 0);
         exp_spike = fire ? (9'd1 << lvl) : 9'd0;
         if (m_gap != 0)      exp_tag = "R6";
         else if (!fire)      exp_tag = "R3";
         else if (t >= B_TRAIN) exp_tag = "R7";
         else if (t >= B_SEG) exp_tag = "R5";
         else                 exp_tag = "R4";
         if (m_gap == 0) begin
            if (m_cnt == B_SEG - 1) begin
               m_sel = 1 - m_sel;
               m_cnt = 0;
               if (t + 1 < B_TRAIN) m_gap = 1;
            end else m_cnt++;
         end else begin
            if (m_cnt == B_GAP - 1) begin
               m_gap = 0;
               m_cnt = 0;
            end else m_cnt++;
         end
         exp_sel = m_sel[0];
         t++;
      end else begin
         exp_spike = 9'd0;
         exp_tag   = "R2";
      end
   endtask

   task automatic reset_dut(input logic [7:0] pa, input logic [7:0] pb);
      @(negedge clk);
      rst_n = 1'b0;
      slice_i = 1'b0;
      period_a = pa;
      period_b = pb;
      repeat (3) @(negedge clk);
      // R1 outputs held low in reset
      check_bits(spike_q4, 9'd0, "R1", "reset spike");
      check_bits({8'd0, wave_q4}, 9'd0, "R1", "reset flag");
      rst_n = 1'b1;
      t = 0; m_sel = 0; m_gap = 0; m_cnt = 0;
      exp_spike = 9'd0;
      exp_sel = 1'b0;
      exp_tag = "R1";
   endtask

   initial begin
      // run 1: periods 43/133, strobe every second cycle
      reset_dut(8'd43, 8'd133);
      for (int c = 0; t < N_SLICE; c++) do_cycle(c[0] == 1'b0);
      do_cycle(1'b0);
      // run 2: extreme periods, bursts of back-to-back strobes
      reset_dut(8'd32, 8'd255);
      for (int c = 0; t < N_SLICE; c++) do_cycle((c % 7) inside {0, 1, 2, 4});
      do_cycle(1'b0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule